// File: doc/BRIEF.md
# Asynchronous DRAM Access Sequencer with Programmable Address Split

This block serves one internal read or write at a time against up to four banks of asynchronous DRAM, each of either the plain or the extended-data-out kind. Each bank has a 32-bit configuration word, supplied on an input port. The word places the bank in the address space in 64 KB pages. It also sets the column width, the row-to-column delay, the precharge length and the bank's DRAM type. The address bus is 26 bits wide, so a page index is the 10 bits above bit 15.

A request is held on `reqValid` until `reqReady` pulses. The block picks the bank whose page window holds the address. It splits the address into column, row and internal-bank-select parts, using the column width of that bank. The row phase puts the row and the select bit on the shared pins and pulls that bank's row strobe low. After the programmed delay the column phase drives the column and pulls the column strobe low for one cycle. The block then releases both strobes and waits out the precharge before it answers.

Top module: `dram_edo_ctl`

## Requirements
- R1: A bank's configuration word has its edo select at bit 0, its row-to-column bit at bit 7, its precharge code at bits 9:8, its base page at bits 19:10, its next page (last page + 1) at bits 29:20 and its column code at bits 31:30. An address hits bank i when base <= addr[25:16] < next. When several banks hit, the lowest index is used. When no bank hits, no row strobe falls, `reqReady` pulses one cycle after acceptance and `rspRdata` is 0.
- R2: Column code 0, 1, 2 or 3 selects 8, 9, 10 or 11 column bits. In the column phase, pins 12:0 carry addr[cw-1:0], zero-extended, where cw is the column width.
- R3: In the row phase, pins 12:0 carry the 13 address bits starting at bit cw. Pin 13 carries addr[cw+13] in both the row phase and the column phase.
- R4: The row strobe of the selected bank stays low for 1 cycle (row-to-column bit 0) or 2 cycles (bit 1) before the column strobe falls. The column strobe is only ever low while a row strobe is low.
- R5: The column strobe is low for exactly one cycle per access. For a write, the write enable is low only in that cycle, `dramOe` is high in it and `dramDout` equals the write data. For a read, the write enable stays high.
- R6: Precharge code 0 to 3 gives 1 to 4 cycles with every row strobe high before `reqReady`.
- R7: A plain bank captures read data at the end of the column strobe cycle. An edo bank captures it at the end of the following cycle, with the column strobe high and the row strobe still low, which adds one cycle to the access.
- R8: `reqReady` is a one-cycle pulse. Counting clock edges from the edge that accepts the request up to the edge that raises `reqReady`, a hit takes 4 + rcd + pre + edo edges, where rcd, pre and edo are the raw field values. `rspRdata` holds the captured word for a read and 0 for a write.
- R9: While reset is active, all row strobes, the column strobe and the write enable are high, and `reqReady` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present; held until reqReady |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Internal byte address |
| reqWdata | input | DATA_W | Write data |
| reqReady | output | 1 | One-cycle completion pulse |
| rspRdata | output | DATA_W | Read result, valid with reqReady |
| bankCfg | input | 32*NUM_BANKS | Per-bank configuration words, bank 0 in the low word |
| rasN | output | NUM_BANKS | Row strobes, one per bank, active low |
| casN | output | 1 | Shared column strobe, active low |
| weN | output | 1 | Write enable, active low |
| dramAddr | output | ROW_W+1 | Multiplexed row/column pins plus bank-select pin |
| dramOe | output | 1 | Data pins driven by the block |
| dramDout | output | DATA_W | Write data to the DRAM |
| dramDin | input | DATA_W | Read data from the DRAM |

## Verification
The assertions assume that `reqValid` and the request fields stay steady until `reqReady`, and that `bankCfg` changes only while no access is in flight. The driver raises one request at a time, drops it on the ready cycle and rewrites the configuration only between accesses. It also assumes the configured windows are not empty and that an address never maps its column, row and select bits onto the same pins as another address used in the same bank. The chosen addresses are distinct in those fields, so a DRAM model keyed on the observed pins can stand in for the memory.

// File: rtl/dram_ctl_pkg.sv
`timescale 1ns/1ps
package dram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RAS, ST_CAS, ST_HOLD, ST_PRE, ST_DONE
  } seqState_t;

  typedef struct packed {
    logic accept;   // latch request
    logic rasOn;    // selected bank row strobe active
    logic colSel;   // column on the pins
    logic casOn;    // column strobe active
    logic capture;  // sample read data
  } seqStrobe_t;

  typedef struct packed {
    logic [1:0] colCode;
    logic [9:0] nextPage;
    logic [9:0] basePage;
    logic [1:0] preCode;
    logic       rcdSel;
    logic       edoSel;
  } bankCfg_t;

  function automatic bankCfg_t unpackCfg(input logic [31:0] w);
    bankCfg_t c;
    c.edoSel   = w[0];
    c.rcdSel   = w[7];
    c.preCode  = w[9:8];
    c.basePage = w[19:10];
    c.nextPage = w[29:20];
    c.colCode  = w[31:30];
    return c;
  endfunction

endpackage

// File: rtl/dram_seq_ctrl.sv
`timescale 1ns/1ps
module dram_seq_ctrl
  import dram_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       hit,
  input  logic       edo,
  input  logic       rcdSel,
  input  logic [1:0] preCode,
  output seqStrobe_t strobe,
  output logic       reqReady
);

  seqState_t state;
  logic [1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (reqValid) begin
          state <= hit ? ST_RAS : ST_DONE;
          cnt   <= '0;
        end
        ST_RAS: if (cnt == {1'b0, rcdSel}) begin
          state <= ST_CAS;
          cnt   <= '0;
        end else cnt <= cnt + 2'd1;
        ST_CAS: begin
          state <= edo ? ST_HOLD : ST_PRE;
          cnt   <= '0;
        end
        ST_HOLD: state <= ST_PRE;
        ST_PRE: if (cnt == preCode) begin
          state <= ST_DONE;
          cnt   <= '0;
        end else cnt <= cnt + 2'd1;
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.accept  = (state == ST_IDLE) && reqValid;
    strobe.rasOn   = (state == ST_RAS) || (state == ST_CAS) || (state == ST_HOLD);
    strobe.colSel  = (state == ST_CAS) || (state == ST_HOLD);
    strobe.casOn   = (state == ST_CAS);
    strobe.capture = ((state == ST_CAS) && !edo) || ((state == ST_HOLD) && edo);
    reqReady       = (state == ST_DONE);
  end

endmodule

// File: rtl/dram_addr_path.sv
`timescale 1ns/1ps
module dram_addr_path
  import dram_ctl_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 26,
  parameter int ROW_W     = 13,
  parameter int DATA_W    = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  seqStrobe_t              strobe,
  input  logic                    reqWrite,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [DATA_W-1:0]       reqWdata,
  input  logic [32*NUM_BANKS-1:0] bankCfg,
  output logic                    hit,
  output logic                    edo,
  output logic                    rcdSel,
  output logic [1:0]              preCode,
  output logic [NUM_BANKS-1:0]    rasN,
  output logic                    casN,
  output logic                    weN,
  output logic [ROW_W:0]          dramAddr,
  output logic                    dramOe,
  output logic [DATA_W-1:0]       dramDout,
  input  logic [DATA_W-1:0]       dramDin,
  output logic [DATA_W-1:0]       rspRdata
);

  localparam int SEL_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int PAGE_LO = 16;
  localparam int PAGE_W  = 10;
  localparam int COL_MIN = 8;

  bankCfg_t             cfgArr [NUM_BANKS];
  logic [NUM_BANKS-1:0] hitVec;
  logic [PAGE_W-1:0]    page;
  logic [SEL_W-1:0]     selIdx;
  bankCfg_t             selCfg;

  assign page = PAGE_W'(reqAddr >> PAGE_LO);

  for (genvar i = 0; i < NUM_BANKS; i++) begin : gBank
    assign cfgArr[i] = unpackCfg(bankCfg[32*i +: 32]);
    assign hitVec[i] = (page >= cfgArr[i].basePage) && (page < cfgArr[i].nextPage);
    assign rasN[i]   = !(strobe.rasOn && (lBank == SEL_W'(i)));
  end

  always_comb begin
    selIdx = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--)
      if (hitVec[i]) selIdx = SEL_W'(i);
  end

  assign hit    = |hitVec;
  assign selCfg = cfgArr[selIdx];

  logic [ADDR_W-1:0] lAddr;
  logic              lWrite;
  logic [DATA_W-1:0] lWdata;
  logic [SEL_W-1:0]  lBank;
  logic [1:0]        lColCode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lAddr    <= '0;
      lWrite   <= 1'b0;
      lWdata   <= '0;
      lBank    <= '0;
      lColCode <= '0;
      edo      <= 1'b0;
      rcdSel   <= 1'b0;
      preCode  <= '0;
      rspRdata <= '0;
    end else if (strobe.accept) begin
      lAddr    <= reqAddr;
      lWrite   <= reqWrite;
      lWdata   <= reqWdata;
      lBank    <= selIdx;
      lColCode <= selCfg.colCode;
      edo      <= selCfg.edoSel;
      rcdSel   <= selCfg.rcdSel;
      preCode  <= selCfg.preCode;
      rspRdata <= '0;
    end else if (strobe.capture && !lWrite) begin
      rspRdata <= dramDin;
    end
  end

  logic [4:0]        colWidth;
  logic [ADDR_W-1:0] colMask;
  logic [ROW_W-1:0]  rowPins;
  logic [ROW_W-1:0]  colPins;
  logic              bankBit;

  always_comb begin
    colWidth = 5'(COL_MIN) + 5'(lColCode);
    colMask  = (ADDR_W'(1) << colWidth) - ADDR_W'(1);
    colPins  = ROW_W'(lAddr & colMask);
    rowPins  = ROW_W'(lAddr >> colWidth);
    bankBit  = 1'(lAddr >> (colWidth + 5'(ROW_W)));
    if (!strobe.rasOn)      dramAddr = '0;
    else if (strobe.colSel) dramAddr = {bankBit, colPins};
    else                    dramAddr = {bankBit, rowPins};
  end

  assign casN     = !strobe.casOn;
  assign weN      = !(strobe.casOn && lWrite);
  assign dramOe   = strobe.casOn && lWrite;
  assign dramDout = lWdata;

endmodule

// File: rtl/dram_edo_ctl.sv
`timescale 1ns/1ps
module dram_edo_ctl
  import dram_ctl_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 26,
  parameter int ROW_W     = 13,
  parameter int DATA_W    = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic                    reqWrite,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [DATA_W-1:0]       reqWdata,
  output logic                    reqReady,
  output logic [DATA_W-1:0]       rspRdata,
  input  logic [32*NUM_BANKS-1:0] bankCfg,
  output logic [NUM_BANKS-1:0]    rasN,
  output logic                    casN,
  output logic                    weN,
  output logic [ROW_W:0]          dramAddr,
  output logic                    dramOe,
  output logic [DATA_W-1:0]       dramDout,
  input  logic [DATA_W-1:0]       dramDin
);

  seqStrobe_t strobe;
  logic       hit, edo, rcdSel;
  logic [1:0] preCode;

  dram_seq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .hit(hit), .edo(edo),
    .rcdSel(rcdSel), .preCode(preCode), .strobe(strobe), .reqReady(reqReady)
  );

  dram_addr_path #(
    .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .ROW_W(ROW_W), .DATA_W(DATA_W)
  ) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .bankCfg(bankCfg), .hit(hit),
    .edo(edo), .rcdSel(rcdSel), .preCode(preCode), .rasN(rasN), .casN(casN),
    .weN(weN), .dramAddr(dramAddr), .dramOe(dramOe), .dramDout(dramDout),
    .dramDin(dramDin), .rspRdata(rspRdata)
  );

endmodule

// File: rtl/dram_edo_ctl_chk.sv
`timescale 1ns/1ps
module dram_edo_ctl_chk #(
  parameter int NUM_BANKS = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_BANKS-1:0] rasN,
  input logic                 casN,
  input logic                 weN,
  input logic                 reqReady
);

  assert_ras_onehot_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~rasN));

  assert_cas_under_ras_R4: assert property (@(posedge clk) disable iff (!rstN)
    !casN |-> !(&rasN));

  assert_ras_before_cas_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(casN) |-> !(&$past(rasN)));

  assert_cas_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    !casN |=> casN);

  assert_we_in_cas_R5: assert property (@(posedge clk) disable iff (!rstN)
    !weN |-> !casN);

  assert_ready_precharged_R6: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (&rasN && casN));

  assert_ready_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |=> !reqReady);

  assert_reset_idle_R9: assert property (@(posedge clk)
    !rstN |=> (&rasN && casN && weN && !reqReady));

endmodule

bind dram_edo_ctl dram_edo_ctl_chk #(.NUM_BANKS(NUM_BANKS)) uChk (
  .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .weN(weN),
  .reqReady(reqReady)
);

// File: tb/sim_dram_edo_ctl.sv
`timescale 1ns/1ps
module sim_dram_edo_ctl;

  localparam int NB = 4, AW = 26, RW = 13, DW = 32;
  localparam logic [31:0] UNWRITTEN = 32'hDEADBEEF;
  localparam logic [31:0] NODATA    = 32'hBAD0BAD0;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic reqReady;
  logic [DW-1:0] rspRdata;
  logic [31:0] cfgW [NB];
  logic [32*NB-1:0] bankCfg;
  logic [NB-1:0] rasN;
  logic casN, weN, dramOe;
  logic [RW:0] dramAddr;
  logic [DW-1:0] dramDout;
  logic [DW-1:0] dramDin = NODATA;

  assign bankCfg = {cfgW[3], cfgW[2], cfgW[1], cfgW[0]};

  dram_edo_ctl #(.NUM_BANKS(NB), .ADDR_W(AW), .ROW_W(RW), .DATA_W(DW)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .rspRdata(rspRdata), .bankCfg(bankCfg), .rasN(rasN), .casN(casN),
    .weN(weN), .dramAddr(dramAddr), .dramOe(dramOe), .dramDout(dramDout),
    .dramDin(dramDin)
  );

  always #4 clk = ~clk;

  longint cycleCnt = 0;
  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkCfg(input bit edo, input bit rcd, input int pre,
                                        input int base, input int nxt, input int can);
    logic [31:0] w = '0;
    w[0] = edo; w[7] = rcd; w[9:8] = 2'(pre);
    w[19:10] = 10'(base); w[29:20] = 10'(nxt); w[31:30] = 2'(can);
    return w;
  endfunction

  // DRAM model: acts at the falling edge on the pins set at the rising edge
  logic [31:0] mem [logic [26:0]];
  bit prevCasLow = 0, prevRasAny = 0, casSeen = 0, rasSeen = 0;
  logic [31:0] heldData = NODATA;
  logic [RW:0] obsRow = '0, obsCol = '0;
  int obsBank = 0, rasLowCnt = 0, obsRcd = 0, casCnt = 0;
  bit obsWe = 0, obsOe = 0;
  logic [31:0] obsDout = '0;

  always @(negedge clk) begin
    bit anyRas;
    int bi;
    logic [26:0] key;
    logic [31:0] rd;
    anyRas = !(&rasN);
    bi = 0;
    for (int i = 0; i < NB; i++) if (!rasN[i]) bi = i;
    if (anyRas && !prevRasAny) begin
      obsRow = dramAddr; obsBank = bi; rasSeen = 1; rasLowCnt = 0; casSeen = 0;
    end
    if (anyRas && casN && !casSeen) rasLowCnt++;
    if (!casN) begin
      casSeen = 1; casCnt++;
      obsCol = dramAddr; obsRcd = rasLowCnt;
      obsWe = !weN; obsOe = dramOe; obsDout = dramDout;
      key = {2'(obsBank), obsRow, dramAddr[10:0]};
      if (!weN) mem[key] = dramDout;
      rd = mem.exists(key) ? mem[key] : UNWRITTEN;
      heldData = rd;
      dramDin = cfgW[obsBank][0] ? NODATA : rd;
    end else if (prevCasLow && cfgW[obsBank][0]) begin
      dramDin = heldData;
    end else begin
      dramDin = NODATA;
    end
    prevCasLow = !casN;
    prevRasAny = anyRas;
  end

  typedef struct {
    bit hit; bit wr; int bank; logic [RW:0] row; logic [RW:0] col;
    int rcd; int lat; logic [31:0] data; logic [31:0] wd;
  } expItem_t;

  expItem_t expQ [$];
  logic [31:0] shadow [longint];
  longint reqStart = 0;

  task automatic access(input bit wr, input logic [AW-1:0] addr, input logic [31:0] wd);
    expItem_t e;
    int page, cw;
    page = int'(addr >> 16);
    e.hit = 0; e.bank = 0; e.wr = wr; e.wd = wd;
    for (int i = NB - 1; i >= 0; i--)
      if (page >= int'(cfgW[i][19:10]) && page < int'(cfgW[i][29:20])) begin
        e.hit = 1; e.bank = i;
      end
    cw = 8 + int'(cfgW[e.bank][31:30]);
    e.row = {1'(addr >> (cw + 13)), 13'(addr >> cw)};
    e.col = {1'(addr >> (cw + 13)), 13'(addr & ((26'd1 << cw) - 26'd1))};
    e.rcd = int'(cfgW[e.bank][7]) + 1;
    e.lat = e.hit ? 4 + int'(cfgW[e.bank][7]) + int'(cfgW[e.bank][9:8]) + int'(cfgW[e.bank][0]) : 1;
    if (!e.hit || wr) e.data = '0;
    else e.data = shadow.exists({e.bank, addr}) ? shadow[{e.bank, addr}] : UNWRITTEN;
    if (e.hit && wr) shadow[{e.bank, addr}] = wd;
    expQ.push_back(e);
    rasSeen = 0; casCnt = 0;
    reqValid = 1; reqWrite = wr; reqAddr = addr; reqWdata = wd;
    reqStart = cycleCnt;
    do @(negedge clk); while (!reqReady);
    reqValid = 0;
    @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && reqReady) begin
      expItem_t e;
      if (expQ.size() == 0) check(0, "R8", "unexpected ready", 1, 0);
      else begin
        e = expQ.pop_front();
        check(cycleCnt - reqStart == e.lat, "R8", "latency (R6 R7)", cycleCnt - reqStart, e.lat);
        check(rspRdata == e.data, "R7", "read data", rspRdata, e.data);
        check(rasSeen == e.hit, "R1", "row strobe activity", rasSeen, e.hit);
        if (e.hit) begin
          check(obsBank == e.bank, "R1", "bank selected", obsBank, e.bank);
          check(obsRow == e.row, "R3", "row pins", obsRow, e.row);
          check(obsCol == e.col, "R2", "column pins", obsCol, e.col);
          check(obsRcd == e.rcd, "R4", "row-to-column cycles", obsRcd, e.rcd);
          check(casCnt == 1, "R5", "column strobe cycles", casCnt, 1);
          check(obsWe == e.wr && obsOe == e.wr, "R5", "write enable", obsWe, e.wr);
          if (e.wr) check(obsDout == e.wd, "R5", "write data", obsDout, e.wd);
        end
      end
    end
  end

  task automatic finishSim();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishSim();
  end

  initial begin
    cfgW[0] = mkCfg(0, 0, 0, 'h000, 'h040, 0);
    cfgW[1] = mkCfg(1, 1, 3, 'h040, 'h080, 1);
    cfgW[2] = mkCfg(0, 1, 2, 'h080, 'h0C0, 3);
    cfgW[3] = mkCfg(1, 0, 1, 'h0C0, 'h100, 2);
    repeat (3) @(negedge clk);
    // R9: idle pins during reset
    check(&rasN, "R9", "row strobes in reset", rasN, 4'hF);
    check(casN && weN, "R9", "column strobe/we in reset", {casN, weN}, 2'b11);
    check(!reqReady, "R9", "ready in reset", reqReady, 0);
    rstN = 1;
    @(negedge clk);
    // plain bank, 8 column bits, short timings
    access(1, 26'h0212345, 32'hA1A1_0001);
    access(0, 26'h0212345, 0);
    access(0, 26'h03F00FF, 0);          // last page of bank 0
    // edo bank, 9 column bits, long precharge
    access(1, 26'h0456789, 32'hB2B2_0002);
    access(0, 26'h0456789, 0);
    access(0, 26'h0400000, 0);          // first page of bank 1
    // plain bank, 11 column bits
    access(1, 26'h0ABCDEF, 32'hC3C3_0003);
    access(0, 26'h0ABCDEF, 0);
    // edo bank, 10 column bits, short delay
    access(1, 26'h0F12345, 32'hD4D4_0004);
    access(0, 26'h0F12345, 0);
    // no bank covers this page: R1 miss
    access(0, 26'h1000000, 0);
    access(1, 26'h2345678, 32'h1111_2222);
    // overlapping windows: lowest index wins (R1)
    cfgW[3] = mkCfg(1, 0, 1, 'h080, 'h100, 2);
    @(negedge clk);
    access(0, 26'h0ABCDEF, 0);
    access(0, 26'h0D00000, 0);
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R8", "all responses seen", expQ.size(), 0);
    finishSim();
  end

endmodule